// File: doc/BRIEF.md
# Masked Vector Funnel Shifter

This block performs a double-width funnel shift on every element of a wide vector at once. For each lane it joins two operand elements into a value twice the element width. It shifts that value left or right and keeps one half of it. Elements may be 16, 32 or 64 bits wide. The active vector length may be 128, 256 or 512 bits.

The shift count has two sources. In immediate mode a single 8-bit immediate is shared by every lane. In variable mode each lane takes its count from the matching element of a third operand. The count is always reduced modulo the element width.

A per-lane write mask selects which lanes receive the shift result. A lane whose mask bit is clear either keeps its old destination value (merge) or becomes zero (zeroing). Bits above the active vector length are always cleared. The result is registered one cycle after a valid strobe, and instruction decode is handled elsewhere.

Top module: `vec_funnel_shift`

## Requirements
- R1: With `dir_right_i`=0, each lane returns the upper W bits of the 2W-bit value {first, second} shifted left by the lane count.
- R2: With `dir_right_i`=1, each lane returns the lower W bits of the 2W-bit value {second, first} shifted right by the lane count. The bits of second therefore enter at the top of first.
- R3: The lane count is reduced modulo W. For W=16, an immediate of 19 gives the same result as an immediate of 3.
- R4: With `var_mode_i`=0, first is the lane of `src1_i` and second is the lane of `src2_i`. Every lane uses `imm_i` as its count.
- R5: With `var_mode_i`=1, first is the lane of `dst_i` and second is the lane of `src1_i`. Each lane's count is the matching element of `src2_i`.
- R6: `esize_i` selects the element width W: 0 gives 16 bits, 1 gives 32 bits, and 2 or 3 give 64 bits. Lane k occupies bits [k*W +: W].
- R7: Lane k is controlled by `mask_i[k]`. When the bit is set, the lane gets the shift result. When it is clear, the lane keeps `dst_i` if `zero_i`=0, or becomes zero if `zero_i`=1. An all-ones mask writes every lane.
- R8: `vlen_i` selects the active length: 0 gives 128 bits, 1 gives 256 bits, and 2 or 3 give 512 bits. All result bits at or above the active length are zero.
- R9: A count of zero, after the modulo reduction, returns the first operand's element unchanged in both directions.
- R10: `out_valid_o` is high exactly one cycle after `in_valid_i`. `res_o` is updated only by a valid operation and holds otherwise. Reset clears both outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operation strobe |
| var_mode_i | input | 1 | 0: immediate count, 1: per-lane count |
| dir_right_i | input | 1 | 0: left funnel, 1: right funnel |
| esize_i | input | 2 | Element width select |
| vlen_i | input | 2 | Active vector length select |
| imm_i | input | 8 | Shared shift count |
| zero_i | input | 1 | 1: masked-off lanes become zero |
| mask_i | input | VLEN_MAX/16 | Per-lane write mask |
| dst_i | input | VLEN_MAX | Old destination value; first operand in variable mode |
| src1_i | input | VLEN_MAX | First source |
| src2_i | input | VLEN_MAX | Second source; per-lane counts in variable mode |
| out_valid_o | output | 1 | Result valid |
| res_o | output | VLEN_MAX | Registered result |

## Verification
A table of operations covers both directions at every element width and in both count modes. Counts are chosen near 0, near W-1 and above W, so that a swapped half, a swapped operand order or a missing modulo reduction each produces a distinct mismatch. Mixed mask patterns are combined with reduced vector lengths to separate the merge, zeroing and length-clearing paths. Directed tests then cover:
- a zero count, which must return the first operand;
- two immediates that differ by W, which must give identical results;
- all-clear masks in merge and in zeroing mode;
- the hold of the result when no valid strobe is present.

// File: rtl/fsh_pkg.sv
package fsh_pkg;
  localparam int unsigned GRAN_W = 16;

  typedef enum logic [1:0] {
    ESZ_16  = 2'd0,
    ESZ_32  = 2'd1,
    ESZ_64  = 2'd2,
    ESZ_64B = 2'd3
  } esz_e;

  typedef enum logic [1:0] {
    VL_128  = 2'd0,
    VL_256  = 2'd1,
    VL_512  = 2'd2,
    VL_512B = 2'd3
  } vl_e;

  // log2 of granules per lane
  function automatic int unsigned gran_shift(esz_e e);
    case (e)
      ESZ_16:  return 0;
      ESZ_32:  return 1;
      default: return 2;
    endcase
  endfunction

  // active granule count for a vector length
  function automatic int unsigned act_grans(vl_e v);
    case (v)
      VL_128:  return 8;
      VL_256:  return 16;
      default: return 32;
    endcase
  endfunction
endpackage

// File: rtl/fsh_lane.sv
module fsh_lane #(
  parameter int unsigned W  = 32,
  localparam int unsigned CW = $clog2(W)
) (
  input  logic [W-1:0]  first_i,
  input  logic [W-1:0]  second_i,
  input  logic [CW-1:0] amt_i,
  input  logic          dir_right_i,
  output logic [W-1:0]  res_o
);
  logic [2*W-1:0] cat_l, cat_r, sh_l, sh_r;

  always_comb begin
    cat_l = {first_i, second_i};
    cat_r = {second_i, first_i};
    sh_l  = cat_l << amt_i;
    sh_r  = cat_r >> amt_i;
    res_o = dir_right_i ? sh_r[W-1:0] : sh_l[2*W-1:W];
  end
endmodule

// File: rtl/fsh_bank.sv
module fsh_bank #(
  parameter int unsigned VLEN = 512,
  parameter int unsigned W    = 32,
  localparam int unsigned NL  = VLEN / W,
  localparam int unsigned CW  = $clog2(W)
) (
  input  logic [VLEN-1:0] dst_i,
  input  logic [VLEN-1:0] src1_i,
  input  logic [VLEN-1:0] src2_i,
  input  logic [7:0]      imm_i,
  input  logic            var_mode_i,
  input  logic            dir_right_i,
  output logic [VLEN-1:0] res_o
);
  for (genvar l = 0; l < NL; l++) begin : g_lane
    logic [W-1:0]  first, second;
    logic [CW-1:0] amt;

    always_comb begin
      if (var_mode_i) begin
        first  = dst_i[l*W +: W];
        second = src1_i[l*W +: W];
        amt    = src2_i[l*W +: CW];
      end else begin
        first  = src1_i[l*W +: W];
        second = src2_i[l*W +: W];
        amt    = imm_i[CW-1:0];
      end
    end

    fsh_lane #(.W(W)) u_lane (
      .first_i     (first),
      .second_i    (second),
      .amt_i       (amt),
      .dir_right_i (dir_right_i),
      .res_o       (res_o[l*W +: W])
    );
  end
endmodule

// File: rtl/fsh_merge.sv
module fsh_merge
  import fsh_pkg::*;
#(
  parameter int unsigned VLEN = 512,
  localparam int unsigned NG  = VLEN / GRAN_W
) (
  input  logic [VLEN-1:0] r16_i,
  input  logic [VLEN-1:0] r32_i,
  input  logic [VLEN-1:0] r64_i,
  input  logic [VLEN-1:0] dst_i,
  input  esz_e            esize_i,
  input  vl_e             vlen_i,
  input  logic [NG-1:0]   mask_i,
  input  logic            zero_i,
  output logic [VLEN-1:0] res_o
);
  logic [VLEN-1:0] sel;
  logic [NG-1:0]   lane_en;
  int unsigned     gsh, gact;

  always_comb begin
    case (esize_i)
      ESZ_16:  sel = r16_i;
      ESZ_32:  sel = r32_i;
      default: sel = r64_i;
    endcase
    gsh  = gran_shift(esize_i);
    gact = act_grans(vlen_i);
    for (int g = 0; g < NG; g++) begin
      lane_en[g] = mask_i[g >> gsh];
    end
  end

  for (genvar g = 0; g < NG; g++) begin : g_gran
    always_comb begin
      if (g >= gact)
        res_o[g*GRAN_W +: GRAN_W] = '0;
      else if (lane_en[g])
        res_o[g*GRAN_W +: GRAN_W] = sel[g*GRAN_W +: GRAN_W];
      else if (zero_i)
        res_o[g*GRAN_W +: GRAN_W] = '0;
      else
        res_o[g*GRAN_W +: GRAN_W] = dst_i[g*GRAN_W +: GRAN_W];
    end
  end
endmodule

// File: rtl/vec_funnel_shift.sv
module vec_funnel_shift
  import fsh_pkg::*;
#(
  parameter int unsigned VLEN_MAX = 512,
  localparam int unsigned NG      = VLEN_MAX / GRAN_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                in_valid_i,
  input  logic                var_mode_i,
  input  logic                dir_right_i,
  input  logic [1:0]          esize_i,
  input  logic [1:0]          vlen_i,
  input  logic [7:0]          imm_i,
  input  logic                zero_i,
  input  logic [NG-1:0]       mask_i,
  input  logic [VLEN_MAX-1:0] dst_i,
  input  logic [VLEN_MAX-1:0] src1_i,
  input  logic [VLEN_MAX-1:0] src2_i,
  output logic                out_valid_o,
  output logic [VLEN_MAX-1:0] res_o
);
  logic [VLEN_MAX-1:0] bank_res [3];
  logic [VLEN_MAX-1:0] merged;

  for (genvar i = 0; i < 3; i++) begin : g_bank
    fsh_bank #(.VLEN(VLEN_MAX), .W(GRAN_W << i)) u_bank (
      .dst_i       (dst_i),
      .src1_i      (src1_i),
      .src2_i      (src2_i),
      .imm_i       (imm_i),
      .var_mode_i  (var_mode_i),
      .dir_right_i (dir_right_i),
      .res_o       (bank_res[i])
    );
  end

  fsh_merge #(.VLEN(VLEN_MAX)) u_merge (
    .r16_i   (bank_res[0]),
    .r32_i   (bank_res[1]),
    .r64_i   (bank_res[2]),
    .dst_i   (dst_i),
    .esize_i (esz_e'(esize_i)),
    .vlen_i  (vl_e'(vlen_i)),
    .mask_i  (mask_i),
    .zero_i  (zero_i),
    .res_o   (merged)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      res_o       <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) res_o <= merged;
    end
  end
endmodule

// File: rtl/vec_funnel_shift_chk.sv
module vec_funnel_shift_chk #(
  parameter int unsigned VLEN_MAX = 512,
  localparam int unsigned NG      = VLEN_MAX / 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                in_valid_i,
  input logic                var_mode_i,
  input logic                dir_right_i,
  input logic [1:0]          esize_i,
  input logic [1:0]          vlen_i,
  input logic [7:0]          imm_i,
  input logic                zero_i,
  input logic [NG-1:0]       mask_i,
  input logic [VLEN_MAX-1:0] dst_i,
  input logic [VLEN_MAX-1:0] src1_i,
  input logic [VLEN_MAX-1:0] src2_i,
  input logic                out_valid_o,
  input logic [VLEN_MAX-1:0] res_o
);
  // R10
  valid_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);
  // R10
  valid_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);
  // R10
  res_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(res_o));
  // R7
  zero_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && zero_i && mask_i == '0) |=> res_o == '0);
  // R7
  merge_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !zero_i && mask_i == '0 && vlen_i[1]) |=> res_o == $past(dst_i));
  // R9
  imm_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !var_mode_i && imm_i == 8'd0 && (&mask_i) && vlen_i[1])
      |=> res_o == $past(src1_i));

  if (VLEN_MAX > 128) begin : g_vl
    // R8
    len128_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_valid_i && vlen_i == 2'd0) |=> res_o[VLEN_MAX-1:128] == '0);
  end
endmodule

bind vec_funnel_shift vec_funnel_shift_chk #(.VLEN_MAX(VLEN_MAX)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .var_mode_i  (var_mode_i),
  .dir_right_i (dir_right_i),
  .esize_i     (esize_i),
  .vlen_i      (vlen_i),
  .imm_i       (imm_i),
  .zero_i      (zero_i),
  .mask_i      (mask_i),
  .dst_i       (dst_i),
  .src1_i      (src1_i),
  .src2_i      (src2_i),
  .out_valid_o (out_valid_o),
  .res_o       (res_o)
);

// File: tb/vec_funnel_shift_bench.sv
module vec_funnel_shift_bench;
  localparam int VL = 512;
  localparam int NG = VL / 16;

  typedef struct packed {
    logic        mode;
    logic        dir;
    logic [1:0]  esz;
    logic [1:0]  vl;
    logic [7:0]  imm;
    logic        zero;
    logic [31:0] mask;
    logic [7:0]  seed;
  } vec_t;

  localparam int NT = 13;
  localparam vec_t TBL [NT] = '{
    '{1'b0, 1'b0, 2'd0, 2'd2, 8'd5,   1'b0, 32'hFFFF_FFFF, 8'd1},
    '{1'b0, 1'b1, 2'd0, 2'd2, 8'd5,   1'b0, 32'hFFFF_FFFF, 8'd2},
    '{1'b0, 1'b0, 2'd1, 2'd2, 8'd13,  1'b0, 32'hFFFF_FFFF, 8'd3},
    '{1'b0, 1'b1, 2'd1, 2'd2, 8'd31,  1'b0, 32'hFFFF_FFFF, 8'd4},
    '{1'b0, 1'b0, 2'd2, 2'd2, 8'd47,  1'b0, 32'hFFFF_FFFF, 8'd5},
    '{1'b0, 1'b1, 2'd2, 2'd2, 8'd63,  1'b0, 32'hFFFF_FFFF, 8'd6},
    '{1'b1, 1'b0, 2'd0, 2'd2, 8'd0,   1'b0, 32'hFFFF_FFFF, 8'd7},
    '{1'b1, 1'b1, 2'd1, 2'd2, 8'd0,   1'b0, 32'hFFFF_FFFF, 8'd8},
    '{1'b1, 1'b0, 2'd2, 2'd2, 8'd0,   1'b0, 32'hFFFF_FFFF, 8'd9},
    '{1'b0, 1'b0, 2'd1, 2'd1, 8'd9,   1'b0, 32'h0000_A5A5, 8'd10},
    '{1'b1, 1'b1, 2'd0, 2'd0, 8'd0,   1'b1, 32'h0F0F_0F0F, 8'd11},
    '{1'b0, 1'b1, 2'd2, 2'd2, 8'd200, 1'b0, 32'h0000_005A, 8'd12},
    '{1'b0, 1'b0, 2'd3, 2'd3, 8'd9,   1'b0, 32'hFFFF_FFFF, 8'd13}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0, var_mode = 1'b0, dir_right = 1'b0, zero = 1'b0;
  logic [1:0]    esize = '0, vlen = '0;
  logic [7:0]    imm = '0;
  logic [NG-1:0] mask = '0;
  logic [VL-1:0] dst = '0, src1 = '0, src2 = '0;
  logic          out_valid;
  logic [VL-1:0] res;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vec_funnel_shift u_vec_funnel_shift (
    .clk_i (clk), .rst_ni (rst_n), .in_valid_i (in_valid), .var_mode_i (var_mode),
    .dir_right_i (dir_right), .esize_i (esize), .vlen_i (vlen), .imm_i (imm),
    .zero_i (zero), .mask_i (mask), .dst_i (dst), .src1_i (src1), .src2_i (src2),
    .out_valid_o (out_valid), .res_o (res)
  );

  function automatic logic [VL-1:0] gen(input logic [7:0] s, input int salt);
    logic [VL-1:0] v;
    for (int i = 0; i < VL / 32; i++) begin
      logic [31:0] x;
      x = (32'(s) + 32'(salt) * 32'd77 + 32'd1) * 32'h9E37_79B9 + 32'(i) * 32'h0123_4567;
      v[i*32 +: 32] = x ^ {x[15:0], x[31:16]};
    end
    return v;
  endfunction

  // bit-level reference from the requirements
  function automatic logic [VL-1:0] model(input logic [VL-1:0] d, s1, s2,
      input logic m, dr, input logic [1:0] ez, vl, input logic [7:0] im,
      input logic z, input logic [NG-1:0] mk);
    logic [VL-1:0] o;
    int w, act;
    w   = (ez == 2'd0) ? 16 : (ez == 2'd1) ? 32 : 64;
    act = (vl == 2'd0) ? 128 : (vl == 2'd1) ? 256 : 512;
    for (int l = 0; l < VL / w; l++) begin
      logic [63:0] f, sc, cv;
      int amt;
      f = '0; sc = '0; cv = '0;
      for (int b = 0; b < w; b++) begin
        f[b]  = m ? d[l*w+b]  : s1[l*w+b];
        sc[b] = m ? s1[l*w+b] : s2[l*w+b];
        cv[b] = s2[l*w+b];
      end
      amt = m ? int'(cv % 64'(w)) : int'(im) % w;
      for (int i = 0; i < w; i++) begin
        logic bt;
        int j;
        if (!dr) begin
          j  = w + i - amt;
          bt = (j >= w) ? f[j-w] : sc[j];
        end else begin
          j  = i + amt;
          bt = (j < w) ? f[j] : sc[j-w];
        end
        if (l * w >= act)  o[l*w+i] = 1'b0;
        else if (mk[l])    o[l*w+i] = bt;
        else if (z)        o[l*w+i] = 1'b0;
        else               o[l*w+i] = d[l*w+i];
      end
    end
    return o;
  endfunction

  task automatic chk_vec(input string tag, input logic [VL-1:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_bit(input string tag, input logic act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  // drive at negedge, result sampled at the following negedge
  task automatic run_op(input logic m, dr, input logic [1:0] ez, vl,
      input logic [7:0] im, input logic z, input logic [NG-1:0] mk,
      input logic [VL-1:0] d, s1, s2);
    @(negedge clk);
    var_mode = m; dir_right = dr; esize = ez; vlen = vl; imm = im;
    zero = z; mask = mk; dst = d; src1 = s1; src2 = s2; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [VL-1:0] a, b, c, e, r1, r2;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk_bit("R10 reset valid", out_valid, 1'b0);
    chk_vec("R10 reset res", res, '0);
    rst_n = 1'b1;

    for (int t = 0; t < NT; t++) begin
      vec_t v;
      string tag;
      v = TBL[t];
      a = gen(v.seed, 0); b = gen(v.seed, 1); c = gen(v.seed, 2);
      e = model(a, b, c, v.mode, v.dir, v.esz, v.vl, v.imm, v.zero, v.mask);
      // R1 R2 R4 R5 R6 R7 R8 R3
      tag = $sformatf("%s/%s/R6 row %0d", v.dir ? "R2" : "R1", v.mode ? "R5" : "R4", t);
      run_op(v.mode, v.dir, v.esz, v.vl, v.imm, v.zero, v.mask, a, b, c);
      chk_vec(tag, res, e);
      chk_bit("R10 valid", out_valid, 1'b1);
    end

    a = gen(8'd40, 0); b = gen(8'd41, 1); c = gen(8'd42, 2);
    // R9 zero count returns first
    run_op(1'b0, 1'b0, 2'd1, 2'd2, 8'd0, 1'b0, '1, a, b, c);
    chk_vec("R9 left imm zero", res, b);
    run_op(1'b0, 1'b1, 2'd2, 2'd2, 8'd64, 1'b0, '1, a, b, c);
    chk_vec("R9 right imm 64 on 64-bit", res, b);
    run_op(1'b1, 1'b1, 2'd0, 2'd2, 8'd7, 1'b0, '1, a, b, '0);
    chk_vec("R9 R5 var zero counts", res, a);

    // R3 modulo reduction
    run_op(1'b0, 1'b0, 2'd0, 2'd2, 8'd3, 1'b0, '1, a, b, c);
    r1 = res;
    run_op(1'b0, 1'b0, 2'd0, 2'd2, 8'd19, 1'b0, '1, a, b, c);
    r2 = res;
    chk_vec("R3 imm 19 vs 3", r2, r1);
    chk_vec("R3 imm 3 model", r1, model(a, b, c, 1'b0, 1'b0, 2'd0, 2'd2, 8'd3, 1'b0, '1));

    // R7 all-clear masks
    run_op(1'b0, 1'b0, 2'd1, 2'd2, 8'd5, 1'b0, '0, a, b, c);
    chk_vec("R7 merge keeps dst", res, a);
    run_op(1'b0, 1'b1, 2'd1, 2'd2, 8'd5, 1'b1, '0, a, b, c);
    chk_vec("R7 zeroing", res, '0);

    // R8 length clearing
    run_op(1'b0, 1'b0, 2'd2, 2'd0, 8'd1, 1'b0, '1, a, b, c);
    chk_vec("R8 upper bits clear", {res[VL-1:128], 128'd0}, '0);

    // R10 hold without valid
    r1 = res;
    @(negedge clk);
    src1 = gen(8'd99, 3);
    @(negedge clk);
    chk_bit("R10 valid drop", out_valid, 1'b0);
    chk_vec("R10 hold", res, r1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule